// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is the control sequencer and datapath of a small accumulator machine that runs in several cycles per instruction. Every memory transfer is a separate register-transfer step through a memory address register (MAR) and a memory data register (MDR). The program counter, the instruction register and the accumulator can be observed at every state. The block drives one synchronous single-port memory. A read returns its data one cycle after the address is presented, and a write takes place on the clock edge where the write enable is high.

An instruction is a 16-bit word. Bits [15:12] hold the opcode and bits [11:0] hold a word address. The sequencer works through its states in a fixed order: fetch, decode, operand fetch and execute. Each instruction ends with an updated accumulator or a stored word. An `retire` strobe marks the final cycle of every instruction, so an observer can sample the architectural state on the cycle that follows. A halt instruction parks the sequencer until reset.

Top module: `accfe_top`

## Requirements
- R1: While `rst` is high and after its release, `pcOut`, `accOut` and `memWe` read zero and `halted` reads 0 until the first halt is decoded.
- R2: Fetch places the PC in the MAR, which drives `memAddr`, and increments the PC by one before the instruction executes. In the cycle after `retire`, `pcOut` equals the instruction's address plus one, and the PC never changes by any other step.
- R3: The fetched word goes from memory into the MDR and then into the IR. In the cycle after `retire`, `irOut` equals the word stored at the instruction's address. Opcode is bits [15:12] and the operand address is bits [11:0].
- R4: Opcode 0x1 (load) reads the word at the operand address into the accumulator.
- R5: Opcode 0x3 (add) and opcode 0x4 (subtract) combine the accumulator with the word at the operand address, modulo 2^16.
- R6: Opcode 0x2 (store) copies the accumulator into the MDR and writes it to the operand address. `memWe` is high for exactly one cycle, `memWdata` then equals the accumulator, and the accumulator is unchanged.
- R7: The single-operand opcodes are 0x5 (negate, two's complement), 0x6 (increment), 0x7 (decrement) and 0x8 (clear to zero). None of them reads memory for an operand.
- R8: The number of cycles from one `retire` to the next is 8 for load, add and subtract, 7 for store, and 6 for single-operand opcodes.
- R9: Opcode 0x0 (halt) raises `halted` without a `retire`. After that, the PC and the accumulator hold, no write occurs, and `halted` stays high until reset.
- R10: Opcodes 0x9 to 0xF leave the accumulator and memory unchanged, retire after 6 cycles, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory address, always the MAR |
| memWdata | output | 16 | Write data, always the MDR |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 16 | Read data, valid one cycle after the address |
| pcOut | output | 12 | Program counter |
| irOut | output | 16 | Instruction register |
| accOut | output | 16 | Accumulator |
| retire | output | 1 | High in the last cycle of each instruction |
| halted | output | 1 | Sequencer parked after a halt opcode |

## Verification
The embedded properties assume that reset is held for at least one clock edge. They also assume that the attached memory returns read data exactly one cycle after the address and never stalls, because the sequencer has no wait input. The bench's memory model follows that timing exactly. Every program it loads ends in a halt word within a small address window, so the fetch stream never runs into unloaded memory. A reset in the middle of a run is applied only while `halted` is already high.

// File: rtl/accfe_pkg.sv
`timescale 1ns/1ps
package accfe_pkg;

  localparam int OP_W = 4;

  // Opcode values of the top instruction bits
  localparam logic [OP_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OP_W-1:0] OP_SUB   = 4'h4;
  localparam logic [OP_W-1:0] OP_NEG   = 4'h5;
  localparam logic [OP_W-1:0] OP_INC   = 4'h6;
  localparam logic [OP_W-1:0] OP_DEC   = 4'h7;
  localparam logic [OP_W-1:0] OP_CLR   = 4'h8;

  typedef enum logic [2:0] {
    ALU_HOLD,
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_NEG,
    ALU_INC,
    ALU_DEC,
    ALU_CLR
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_WAIT,
    ST_F_LOAD,
    ST_F_IR,
    ST_DECODE,
    ST_O_WAIT,
    ST_O_LOAD,
    ST_EXEC,
    ST_S_MDR,
    ST_S_WRITE,
    ST_HALTED
  } seq_state_e;

  typedef struct packed {
    logic    marFromPc;
    logic    marFromIr;
    logic    pcInc;
    logic    mdrFromMem;
    logic    mdrFromAcc;
    logic    irFromMdr;
    logic    accWrite;
    logic    memWrite;
    alu_op_e aluOp;
  } ctl_strobe_t;

endpackage

// File: rtl/accfe_alu.sv
`timescale 1ns/1ps
module accfe_alu
  import accfe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opnd,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] result
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    unique case (op)
      ALU_PASS: result = opnd;
      ALU_ADD:  result = accIn + opnd;
      ALU_SUB:  result = accIn - opnd;
      ALU_NEG:  result = ~accIn + ONE;
      ALU_INC:  result = accIn + ONE;
      ALU_DEC:  result = accIn - ONE;
      ALU_CLR:  result = '0;
      default:  result = accIn;
    endcase
  end

endmodule

// File: rtl/accfe_ctrl.sv
`timescale 1ns/1ps
module accfe_ctrl
  import accfe_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] irOp,
  output ctl_strobe_t     strb,
  output logic            retire,
  output logic            halted
);

  seq_state_e stateQ, stateD;

  function automatic alu_op_e decodeAlu(input logic [OP_W-1:0] op);
    case (op)
      OP_LOAD: return ALU_PASS;
      OP_ADD:  return ALU_ADD;
      OP_SUB:  return ALU_SUB;
      OP_NEG:  return ALU_NEG;
      OP_INC:  return ALU_INC;
      OP_DEC:  return ALU_DEC;
      OP_CLR:  return ALU_CLR;
      default: return ALU_HOLD;
    endcase
  endfunction

  function automatic logic needsOperand(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_F_ADDR;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    retire = 1'b0;
    unique case (stateQ)
      ST_F_ADDR: begin
        strb.marFromPc = 1'b1;
        strb.pcInc     = 1'b1;
        stateD         = ST_F_WAIT;
      end
      ST_F_WAIT: stateD = ST_F_LOAD;
      ST_F_LOAD: begin
        strb.mdrFromMem = 1'b1;
        stateD          = ST_F_IR;
      end
      ST_F_IR: begin
        strb.irFromMdr = 1'b1;
        stateD         = ST_DECODE;
      end
      ST_DECODE: begin
        if (irOp == OP_HALT) begin
          stateD = ST_HALTED;
        end else if (irOp == OP_STORE) begin
          strb.marFromIr = 1'b1;
          stateD         = ST_S_MDR;
        end else if (needsOperand(irOp)) begin
          strb.marFromIr = 1'b1;
          stateD         = ST_O_WAIT;
        end else begin
          stateD = ST_EXEC;
        end
      end
      ST_O_WAIT: stateD = ST_O_LOAD;
      ST_O_LOAD: begin
        strb.mdrFromMem = 1'b1;
        stateD          = ST_EXEC;
      end
      ST_EXEC: begin
        strb.aluOp    = decodeAlu(irOp);
        strb.accWrite = 1'b1;
        retire        = 1'b1;
        stateD        = ST_F_ADDR;
      end
      ST_S_MDR: begin
        strb.mdrFromAcc = 1'b1;
        stateD          = ST_S_WRITE;
      end
      ST_S_WRITE: begin
        strb.memWrite = 1'b1;
        retire        = 1'b1;
        stateD        = ST_F_ADDR;
      end
      ST_HALTED: stateD = ST_HALTED;
      default:   stateD = ST_F_ADDR;
    endcase
  end

  assign halted = (stateQ == ST_HALTED);

  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    strb.memWrite |=> !strb.memWrite);                       // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);                                      // R9
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!strb.memWrite && !retire));                 // R9
  AST_FETCH_AFTER_RETIRE: assert property (@(posedge clk) disable iff (rst)
    retire |=> strb.marFromPc);                              // R2

endmodule

// File: rtl/accfe_dpath.sv
`timescale 1ns/1ps
module accfe_dpath
  import accfe_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_strobe_t       strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [OP_W-1:0]   irOp,
  output logic [ADDR_W-1:0] pcQ,
  output logic [DATA_W-1:0] irQ,
  output logic [DATA_W-1:0] accQ
);

  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] mdrQ;
  logic [DATA_W-1:0] aluY;

  accfe_alu #(.DATA_W(DATA_W)) alu_i (
    .accIn (accQ),
    .opnd  (mdrQ),
    .op    (strb.aluOp),
    .result(aluY)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= '0;
      marQ <= '0;
      mdrQ <= '0;
      irQ  <= '0;
      accQ <= '0;
    end else begin
      if (strb.pcInc)           pcQ  <= pcQ + ADDR_W'(1);
      if (strb.marFromPc)       marQ <= pcQ;
      else if (strb.marFromIr)  marQ <= irQ[ADDR_W-1:0];
      if (strb.mdrFromMem)      mdrQ <= memRdata;
      else if (strb.mdrFromAcc) mdrQ <= accQ;
      if (strb.irFromMdr)       irQ  <= mdrQ;
      if (strb.accWrite)        accQ <= aluY;
    end
  end

  assign memAddr  = marQ;
  assign memWdata = mdrQ;
  assign memWe    = strb.memWrite;
  assign irOp     = irQ[DATA_W-1:ADDR_W];

  AST_PC_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (pcQ != $past(pcQ))) |-> (pcQ == $past(pcQ) + ADDR_W'(1)));  // R2
  AST_STORE_DATA_IS_ACC: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (memWdata == accQ));                                              // R6
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    memWe |=> $stable(accQ));                                                   // R6
  AST_STORE_ADDR_FROM_IR: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (memAddr == irQ[ADDR_W-1:0]));                                    // R6

endmodule

// File: rtl/accfe_top.sv
`timescale 1ns/1ps
module accfe_top
  import accfe_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] irOut,
  output logic [DATA_W-1:0] accOut,
  output logic              retire,
  output logic              halted
);

  ctl_strobe_t     strb;
  logic [OP_W-1:0] irOp;

  accfe_ctrl ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .irOp  (irOp),
    .strb  (strb),
    .retire(retire),
    .halted(halted)
  );

  accfe_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memWe   (memWe),
    .irOp    (irOp),
    .pcQ     (pcOut),
    .irQ     (irOut),
    .accQ    (accOut)
  );

endmodule

// File: tb/accfe_top_tb_top.sv
`timescale 1ns/1ps
module accfe_top_tb_top;

  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memWe;
  logic [DW-1:0] memRdata;
  logic [AW-1:0] pcOut;
  logic [DW-1:0] irOut;
  logic [DW-1:0] accOut;
  logic          retire;
  logic          halted;

  always #2.5 clk = ~clk;

  accfe_top dut_i (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .pcOut(pcOut), .irOut(irOut),
    .accOut(accOut), .retire(retire), .halted(halted)
  );

  // Bench-side synchronous memory, one cycle read latency
  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    memRdata <= mem[memAddr[7:0]];
  end

  typedef struct { logic [DW-1:0] ir; logic [AW-1:0] pc; logic [DW-1:0] acc; int len; } expItem_t;
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } stItem_t;
  expItem_t expQ[$];
  stItem_t  stQ[$];

  int nVec = 0;
  int nBad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string accTag(input logic [3:0] op);
    case (op)
      4'h1: return "R4 load result";
      4'h3, 4'h4: return "R5 add/sub result";
      4'h2: return "R6 store keeps acc";
      4'h5, 4'h6, 4'h7, 4'h8: return "R7 single-operand result";
      default: return "R10 undefined opcode keeps acc";
    endcase
  endfunction

  // Driver: runs the reference interpreter over the loaded image and queues expectations
  task automatic driveProgram(output logic [AW-1:0] haltPc);
    logic [DW-1:0] refMem [256];
    logic [AW-1:0] pc;
    logic [DW-1:0] acc;
    for (int i = 0; i < 256; i++) refMem[i] = mem[i];
    pc = '0;
    acc = '0;
    haltPc = '0;
    for (int step = 0; step < 200; step++) begin
      logic [DW-1:0] w;
      logic [3:0]    op;
      logic [AW-1:0] a;
      expItem_t      e;
      w  = refMem[pc[7:0]];
      op = w[15:12];
      a  = w[11:0];
      pc = pc + 1'b1;
      if (op == 4'h0) begin
        haltPc = pc;
        break;
      end
      e.len = 6;
      case (op)
        4'h1: begin acc = refMem[a[7:0]]; e.len = 8; end
        4'h2: begin
          stItem_t s;
          s.a = a; s.d = acc;
          stQ.push_back(s);
          refMem[a[7:0]] = acc;
          e.len = 7;
        end
        4'h3: begin acc = acc + refMem[a[7:0]]; e.len = 8; end
        4'h4: begin acc = acc - refMem[a[7:0]]; e.len = 8; end
        4'h5: acc = -acc;
        4'h6: acc = acc + 1'b1;
        4'h7: acc = acc - 1'b1;
        4'h8: acc = '0;
        default: ;
      endcase
      e.ir = w; e.pc = pc; e.acc = acc;
      expQ.push_back(e);
    end
  endtask

  // Monitor: pops expectations as the design retires instructions and writes
  int       cyc, lastRet, curLen;
  bit       pend, prevWe;
  expItem_t seen;
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; lastRet = 0; pend = 0; prevWe = 0;
    end else begin
      cyc++;
      if (pend) begin
        pend = 0;
        if (expQ.size() == 0) chk("R9 retire with no instruction expected", 1, 0);
        else begin
          seen = expQ.pop_front();
          chk("R3 IR holds fetched word", irOut, seen.ir);
          chk("R2 PC is instruction address plus one", pcOut, seen.pc);
          chk(accTag(seen.ir[15:12]), accOut, seen.acc);
          chk(seen.len == 6 ? "R8/R10 single-operand cycle count" : "R8 instruction cycle count",
              curLen, seen.len);
        end
      end
      if (retire) begin
        pend = 1;
        curLen = cyc - lastRet;
        lastRet = cyc;
      end
      if (memWe) begin
        chk("R6 write enable lasts one cycle", prevWe, 0);
        if (stQ.size() == 0) chk("R6/R9 unexpected memory write", 1, 0);
        else begin
          stItem_t s;
          s = stQ.pop_front();
          chk("R6 store address", memAddr, s.a);
          chk("R6 store data", memWdata, s.d);
        end
      end
      prevWe = memWe;
    end
  end

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic runAndHalt(input string name);
    logic [AW-1:0] haltPc;
    logic [DW-1:0] accHold;
    bit            done;
    driveProgram(haltPc);
    @(negedge clk);
    chk("R1 reset PC", pcOut, 0);
    chk("R1 reset acc", accOut, 0);
    chk("R1 reset write enable", memWe, 0);
    chk("R1 reset halted", halted, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R2 first fetch address is PC 0", memAddr, 0);
    done = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (halted) begin done = 1; break; end
    end
    chk({"R9 program halts: ", name}, done, 1);
    repeat (2) @(negedge clk);
    chk("R9 all instructions retired before halt", expQ.size(), 0);
    chk("R6 all stores performed", stQ.size(), 0);
    chk("R9 halted PC", pcOut, haltPc);
    accHold = accOut;
    repeat (12) @(negedge clk);
    chk("R9 halted stays high", halted, 1);
    chk("R9 PC holds while halted", pcOut, haltPc);
    chk("R9 acc holds while halted", accOut, accHold);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    clearMem();
    // Program A
    mem[8'h80] = 16'h1234;
    mem[8'h81] = 16'hF00F;
    mem[8'h82] = 16'h0300;
    mem[0]  = 16'h1080;  // load
    mem[1]  = 16'h3081;  // add with wrap
    mem[2]  = 16'h2090;  // store
    mem[3]  = 16'h4082;  // subtract below zero
    mem[4]  = 16'h5000;  // negate
    mem[5]  = 16'h6000;  // increment
    mem[6]  = 16'h7000;  // decrement
    mem[7]  = 16'h7000;
    mem[8]  = 16'h9ABC;  // undefined
    mem[9]  = 16'h2091;  // store
    mem[10] = 16'h8000;  // clear
    mem[11] = 16'h7000;  // decrement from zero
    mem[12] = 16'h6000;  // increment to zero
    mem[13] = 16'h1090;  // reload stored word
    mem[14] = 16'hF123;  // undefined
    mem[15] = 16'h0000;  // halt
    repeat (3) @(posedge clk);
    #1;
    runAndHalt("A");
    chk("R6 stored word in memory", mem[8'h90], 16'h0243);
    chk("R6 second stored word in memory", mem[8'h91], 16'h00BC);
    // Program B after reset from a non-zero accumulator
    clearMem();
    mem[8'h40] = 16'h8001;
    mem[0] = 16'h1040;  // load
    mem[1] = 16'h5000;  // negate 0x8001
    mem[2] = 16'h2040;  // store over operand
    mem[3] = 16'h3040;  // add stored value
    mem[4] = 16'hE040;  // undefined
    mem[5] = 16'h4040;  // subtract
    mem[6] = 16'h0000;  // halt
    repeat (2) @(posedge clk);
    #1;
    runAndHalt("B");
    chk("R6 program B store", mem[8'h40], 16'h7FFF);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule